// File: doc/BRIEF.md
# SPI interrupt flag and enable unit

This block collects the interrupt sources of a serial peripheral interface and turns them into one level interrupt request. The SPI datapath supplies a one-cycle strobe when a received character is complete and another when a transmission has finished. It also supplies a level that is high while the transmit data register is empty. The block holds one flag per source, an enable mask, and a registered request line that is high while any flagged source is also enabled.

Software reaches the block through a small register bus. Each write is a single cycle, and reads are combinational. One address shows the flags, and writing ones to it clears the matching flags. The enable mask has two addresses: writing ones to the first turns sources on, and writing ones to the second turns them off. Zero bits in any write leave the other bits alone. Because of this, two agents can change different enables without a read-modify-write. The empty-register flag follows its status level, so software cannot clear it while the register stays empty.

Top module: `spi_irq_unit`

## Requirements
- R1: A strobe on `rx_done_i` sets flag bit 2, and a strobe on `tx_done_i` sets flag bit 1. The flag is set at the next clock edge whether or not that source is enabled, and it stays set until cleared.
- R2: Flag bit 0 copies `txbuf_empty_i` one clock later. Writing a one to bit 0 of the flag address does not clear it while `txbuf_empty_i` is high.
- R3: A write to address 0 clears each of flag bits 1 and 2 whose write bit is one. Zero bits leave their flags unchanged.
- R4: A write that clears a flag in the same cycle as a new strobe for that flag leaves the flag set.
- R5: A write to address 1 sets each enable bit whose write bit is one (bit 0 empty, bit 1 transmit, bit 2 receive). Other enables are unchanged.
- R6: A write to address 2 clears each enable bit whose write bit is one. Other enables are unchanged.
- R7: Reading address 0 returns the flags. Reading address 1 or 2 returns the enable mask. Reading address 3 returns zero. Bits 7..3 always read as zero.
- R8: `irq_o` equals the OR of (flag AND enable) over the three sources, as held one clock earlier. A change of a flag or an enable therefore shows on `irq_o` one clock after the flag or enable register itself changes.
- R9: Once asserted, `irq_o` stays high until the flag is cleared or the source is disabled. It falls one clock after either of these.
- R10: Reset clears all flags and enables and holds `irq_o` low.
- R11: A write to address 3 changes no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | One-cycle strobe: a received character is complete |
| tx_done_i | input | 1 | One-cycle strobe: a transmission has finished |
| txbuf_empty_i | input | 1 | Level: the transmit data register is empty |
| bus_wen_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (2) | Register address |
| bus_wdata_i | input | DATA_W (8) | Register write data |
| bus_rdata_o | output | DATA_W (8) | Register read data, combinational from the address |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench sweeps all eight enable masks against all eight source patterns. After each pattern it checks the flags, both enable read-backs and the request level. A flag wrongly gated by its enable would fail these checks, and so would a request that ignores the mask. It sets a strobe and a clear on the same flag in one cycle, where a design with the wrong priority silently loses an event. It also tries to clear the empty flag while the register is still empty, which a plain write-one-to-clear design would allow. It measures the exact one-cycle latency of the request both when it rises and when it falls through a disable or a clear. A design that registers the request on the wrong side, or that drops it with a delay, shows up there. Zero-valued writes, writes to the spare address and a reset in mid-operation confirm that nothing else moves.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned NSRC    = 3;
    localparam int unsigned SRC_DRE = 0;
    localparam int unsigned SRC_TXC = 1;
    localparam int unsigned SRC_RXC = 2;

    // sources whose flag follows a level instead of latching a strobe
    localparam logic [NSRC-1:0] LEVEL_SRC_MASK = 3'b001;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        REG_FLAG  = 2'd0,
        REG_ENSET = 2'd1,
        REG_ENCLR = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_t;

endpackage

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
    parameter int unsigned      NSRC       = 3,
    parameter logic [NSRC-1:0]  LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o
);

    typedef struct packed {
        logic [NSRC-1:0] flags;
    } flag_st_t;

    flag_st_t        st_d, st_q;
    logic [NSRC-1:0] nxt;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            // status-driven: software clear has no lasting effect
            assign nxt[i] = ev_i[i];
        end else begin : g_sticky
            // a new event overrides a clear in the same cycle
            assign nxt[i] = (st_q.flags[i] & ~clr_i[i]) | ev_i[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] en_o
);

    typedef struct packed {
        logic [NSRC-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/spi_irq_req.sv
module spi_irq_req #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_o
);

    typedef struct packed {
        logic irq;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(flags_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FLAG_ADDR  = 0,
    parameter int unsigned ENSET_ADDR = 1,
    parameter int unsigned ENCLR_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done_i,
    input  logic              tx_done_i,
    input  logic              txbuf_empty_i,
    input  logic              bus_wen_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(ENSET_ADDR);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(ENCLR_ADDR);
    localparam int unsigned       PAD_W   = DATA_W - NSRC;

    typedef struct packed {
        reg_sel_t sel;
        src_vec_t flag_clr;
        src_vec_t en_set;
        src_vec_t en_clr;
        src_vec_t rd_src;
    } dec_t;

    dec_t     dec;
    src_vec_t ev_vec;
    src_vec_t wr_bits;
    src_vec_t flags_w;
    src_vec_t en_w;

    assign ev_vec[SRC_DRE] = txbuf_empty_i;
    assign ev_vec[SRC_TXC] = tx_done_i;
    assign ev_vec[SRC_RXC] = rx_done_i;

    assign wr_bits = bus_wdata_i[NSRC-1:0];

    if (DATA_W > NSRC) begin : g_pad
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NSRC];
        assign bus_rdata_o     = {{PAD_W{1'b0}}, dec.rd_src};
    end else begin : g_nopad
        assign bus_rdata_o = dec.rd_src;
    end

    always_comb begin
        dec = '0;
        if (bus_addr_i == A_FLAG) begin
            dec.sel = REG_FLAG;
        end else if (bus_addr_i == A_ENSET) begin
            dec.sel = REG_ENSET;
        end else if (bus_addr_i == A_ENCLR) begin
            dec.sel = REG_ENCLR;
        end else begin
            dec.sel = REG_NONE;
        end
        case (dec.sel)
            REG_FLAG: begin
                dec.rd_src = flags_w;
                if (bus_wen_i) dec.flag_clr = wr_bits;
            end
            REG_ENSET: begin
                dec.rd_src = en_w;
                if (bus_wen_i) dec.en_set = wr_bits;
            end
            REG_ENCLR: begin
                dec.rd_src = en_w;
                if (bus_wen_i) dec.en_clr = wr_bits;
            end
            default: dec.rd_src = '0;
        endcase
    end

    spi_irq_flags #(
        .NSRC       (NSRC),
        .LEVEL_MASK (LEVEL_SRC_MASK)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_vec),
        .clr_i   (dec.flag_clr),
        .flags_o (flags_w)
    );

    spi_irq_mask #(
        .NSRC (NSRC)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dec.en_set),
        .clr_i (dec.en_clr),
        .en_o  (en_w)
    );

    spi_irq_req #(
        .NSRC (NSRC)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_w),
        .en_i    (en_w),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker
    import spi_irq_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input src_vec_t ev,
    input src_vec_t clr,
    input src_vec_t en_set,
    input src_vec_t en_clr,
    input src_vec_t flags,
    input src_vec_t en,
    input logic     irq
);

    localparam src_vec_t PULSE = ~LEVEL_SRC_MASK;

    AST_STROBE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & PULSE) != '0) |=> ((flags & $past(ev & PULSE)) == $past(ev & PULSE))); // R1

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~clr & PULSE) != '0) |=> ((flags & $past(flags & ~clr & PULSE)) == $past(flags & ~clr & PULSE))); // R1

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~ev & PULSE) != '0) |=> ((flags & $past(clr & ~ev & PULSE)) == '0)); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ev & PULSE) != '0) |=> ((flags & $past(clr & ev & PULSE)) == $past(clr & ev & PULSE))); // R4

    AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flags[SRC_DRE] == $past(ev[SRC_DRE]))); // R2

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set != '0) |=> ((en & $past(en_set)) == $past(en_set))); // R5

    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((en & $past(en_clr)) == '0)); // R6

    AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_set == '0) && (en_clr == '0)) |=> $stable(en)); // R11

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == |$past(flags & en))); // R8

endmodule

bind spi_irq_unit spi_irq_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_vec),
    .clr    (dec.flag_clr),
    .en_set (dec.en_set),
    .en_clr (dec.en_clr),
    .flags  (flags_w),
    .en     (en_w),
    .irq    (irq_o)
);

// File: tb/spi_irq_unit_bench.sv
module spi_irq_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_done = 1'b0;
    logic       tx_done = 1'b0;
    logic       dre = 1'b0;
    logic       wen = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_unit u_spi_irq_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_done_i     (rx_done),
        .tx_done_i     (tx_done),
        .txbuf_empty_i (dre),
        .bus_wen_i     (wen),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .irq_o         (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wen = 1'b1; addr = a; wdata = d;
        tick();
        wen = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic rx, input logic tx);
        rx_done = rx; tx_done = tx;
        tick();
        rx_done = 1'b0; tx_done = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL WDOG: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        // R10: state during reset
        rd(2'd0, v); chk("R10 flags in reset", v, 8'h00);
        chk("R10 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        tick();
        rd(2'd0, v); chk("R10 flags after reset", v, 8'h00);
        rd(2'd1, v); chk("R10 enables after reset", v, 8'h00);
        chk("R10 irq after reset", irq, 1'b0);

        // sweep: every enable mask against every source pattern
        for (int e = 0; e < 8; e++) begin
            for (int f = 0; f < 8; f++) begin
                dre = f[0];
                wr(2'd1, 8'(e));
                pulse(f[2], f[1]);
                tick();
                rd(2'd0, v); chk("R1 R2 flags follow events", v, 8'(f));
                rd(2'd1, v); chk("R7 enable read at address 1", v, 8'(e));
                rd(2'd2, v); chk("R7 enable read at address 2", v, 8'(e));
                chk("R8 irq level", irq, 1'(|(f & e)));
                wr(2'd0, 8'hFF);
                rd(2'd0, v); chk("R3 R2 clear leaves only empty flag", v, 8'(f & 1));
                wr(2'd2, 8'hFF);
                dre = 1'b0;
                tick();
                tick();
                rd(2'd0, v); chk("R3 flags cleared", v, 8'h00);
                rd(2'd1, v); chk("R6 enables cleared", v, 8'h00);
                chk("R9 irq dropped", irq, 1'b0);
            end
        end

        // zero-valued writes change nothing
        pulse(1'b1, 1'b1);
        wr(2'd1, 8'h07);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R3 zero write keeps flags", v, 8'h06);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd1, v); chk("R5 R6 zero writes keep enables", v, 8'h07);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R6 partial disable", v, 8'h05);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R5 partial enable", v, 8'h07);

        // spare address
        wr(2'd3, 8'hFF);
        rd(2'd0, v); chk("R11 flags untouched by spare write", v, 8'h06);
        rd(2'd1, v); chk("R11 enables untouched by spare write", v, 8'h07);
        rd(2'd3, v); chk("R7 spare address reads zero", v, 8'h00);

        // same-cycle strobe and clear
        rx_done = 1'b1;
        wr(2'd0, 8'h06);
        rx_done = 1'b0;
        rd(2'd0, v); chk("R4 strobe wins over clear", v, 8'h04);

        // request latency on rise, disable and clear
        wr(2'd0, 8'h07);
        wr(2'd2, 8'h07);
        wr(2'd1, 8'h02);
        tick();
        chk("R8 irq idle", irq, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R8 irq not yet raised", irq, 1'b0);
        tick();
        chk("R8 irq raised one clock later", irq, 1'b1);
        repeat (3) tick();
        chk("R9 irq held while flagged", irq, 1'b1);
        wr(2'd2, 8'h02);
        chk("R9 irq held until mask registered", irq, 1'b1);
        tick();
        chk("R9 irq dropped after disable", irq, 1'b0);
        wr(2'd1, 8'h02);
        tick();
        chk("R8 irq back after enable", irq, 1'b1);
        wr(2'd0, 8'h02);
        chk("R9 irq held until flag registered", irq, 1'b1);
        tick();
        chk("R9 irq dropped after clear", irq, 1'b0);

        // empty flag cannot be cleared while empty
        dre = 1'b1;
        wr(2'd1, 8'h01);
        tick();
        wr(2'd0, 8'h01);
        tick();
        rd(2'd0, v); chk("R2 empty flag survives clear", v, 8'h01);
        chk("R2 irq stays with empty flag", irq, 1'b1);
        dre = 1'b0;
        tick();
        rd(2'd0, v); chk("R2 empty flag follows status", v, 8'h00);
        tick();
        chk("R9 irq follows empty flag", irq, 1'b0);

        // reset in mid-operation
        dre = 1'b1;
        pulse(1'b1, 1'b1);
        wr(2'd1, 8'h07);
        tick();
        rst_n = 1'b0;
        #1;
        rd(2'd0, v); chk("R10 reset clears flags", v, 8'h00);
        rd(2'd1, v); chk("R10 reset clears enables", v, 8'h00);
        chk("R10 reset clears irq", irq, 1'b0);
        dre = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        tick();
        chk("R10 irq low after reset", irq, 1'b0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule